// File: doc/BRIEF.md
# Chained Periodic Interrupt Timer

This block is a set of down-counting timer channels behind a simple 32-bit register bus. Software gives each channel a reload value and turns it on. From then on the channel counts toward zero, one step per clock. When the count is zero it reloads, raises a sticky timeout flag and, if interrupts are enabled for that channel, asserts that channel's interrupt line. The elapsed time since the last reload is the reload value minus the current count. The block is clocked from the timer reference, nominally 50 MHz (20 ns per step).

Any channel other than the first can be linked to the channel below it. A linked channel then steps only in the cycles where its lower neighbour wraps, so two 32-bit channels form one 64-bit counter. A dedicated pair of read addresses returns that 64-bit value as an upper word and a lower word. Reading the upper word captures the lower channel's count, so the pair read in that order is coherent. A global stop bit freezes every channel at once while the registers stay accessible.

Bus reads are registered: the data for a read request appears on `bus_rdata` in the following cycle, and `bus_rdata` is zero in every other cycle.

Top module: `pit_chain_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `bus_rdata` is zero and no interrupt line is asserted.
- R2: Register map, word aligned, with nonzero `bus_addr[1:0]` treated as unmapped. The global control word is at 0x000, and its bit 1 is the global stop bit. Channel n occupies 0x100+16·n: reload value at +0x0 (read/write), current count at +0x4 (read-only), control at +0x8 and flag at +0xC. Reads of unmapped addresses, including channel slots at or above NCH, return zero. Read data appears one cycle after the request and is zero otherwise.
- R3: An enabled, unlinked channel decrements by one each cycle. In a cycle where its count is zero it reloads the reload value and sets its flag (flag bit 0) in that same update, so a channel with reload L wraps every L+1 cycles.
- R4: Control bit 0 is the channel enable. A write that sets it while it was clear loads the count from the reload value. While it is clear the count holds.
- R5: Control bit 2 links a channel n>0 to channel n−1. A linked channel steps only in cycles where channel n−1 wraps. Channel 0 ignores bit 2.
- R6: While the global stop bit is set, no count changes and no flag is set, and register writes and reads still take effect.
- R7: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the flag stays set.
- R8: Interrupt line n is high exactly when channel n's flag is set and its control bit 1 (interrupt enable) is set.
- R9: A read of 0x0E0 returns channel 1's count and captures channel 0's count in the same cycle. A read of 0x0E4 returns the last captured value.
- R10: Writes to a current-count register, to 0x0E0 or to 0x0E4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, one count step per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus request in this cycle |
| bus_wr | input | 1 | 1 for a write request, 0 for a read request |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The bench aims at the wrap cycle. A design that reloads one cycle late, or sets the flag a cycle after the reload, shows a period of L+2 or an interrupt shifted by one cycle. A design that reloads in the cycle its enable is reasserted only as a side effect would show up on a count read right after re-enable. Linked channels are driven with the lower neighbour at reload 0 and 1. A chain that follows the neighbour's enable instead of its wrap, or a channel 0 that obeys its link bit, then counts at the wrong rate. The test also covers a flag clear in the same cycle as a wrap, where set must win, and a global stop in the middle of a count. It also reads the upper/lower word pair while channel 0 is still running; a design that does not capture the lower word returns a torn 64-bit value.

// File: rtl/pit_pkg.sv
// Shared constants and types for the chained periodic interrupt timer.
// Assumes a fixed 12-bit, word-aligned register map.
package pit_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned MAP_AW   = 12;
    localparam int unsigned IDX_W    = 4;

    localparam logic [MAP_AW-1:0] ADDR_GCTRL   = 12'h000;
    localparam logic [MAP_AW-1:0] ADDR_LIFE_HI = 12'h0E0;
    localparam logic [MAP_AW-1:0] ADDR_LIFE_LO = 12'h0E4;
    localparam logic [3:0]        CH_REGION    = 4'h1;
    localparam int unsigned       GSTOP_BIT    = 1;

    typedef enum logic [1:0] {
        CH_RELOAD = 2'd0,
        CH_COUNT  = 2'd1,
        CH_CTRL   = 2'd2,
        CH_FLAG   = 2'd3
    } ch_reg_e;

    // Channel control word, bit 0 = run, bit 1 = irq enable, bit 2 = link
    typedef struct packed {
        logic link;
        logic irq_en;
        logic run;
    } ch_ctrl_t;

endpackage

// File: rtl/pit_channel.sv
// One timer channel: reload register, down counter, control and sticky flag.
// Assumes the top supplies one-cycle write strobes and the lower neighbour's
// wrap pulse. FIRST marks channel 0, which ignores its link bit.
module pit_channel
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter bit          FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             link_in,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             ctrl_we,
    input  ch_ctrl_t         ctrl_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] count_q,
    output ch_ctrl_t         ctrl_q,
    output logic             flag_q,
    output logic             wrap,
    output logic             irq
);

    logic link_ok;
    logic step;
    logic start;

    // Decide whether this channel may step in the current cycle
    always_comb begin
        link_ok = FIRST || !ctrl_q.link || link_in;
        step    = run && ctrl_q.run && link_ok;
        wrap    = step && (count_q == '0);
        start   = ctrl_we && ctrl_wdata.run && !ctrl_q.run;
    end

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_we) reload_q <= reload_wdata;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Down counter with reload on wrap and load on enable
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (start)      count_q <= reload_q;
        else if (wrap)       count_q <= reload_q;
        else if (step)       count_q <= count_q - 1'b1;
    end

    // Sticky timeout flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Interrupt request gated by the enable
    always_comb irq = flag_q && ctrl_q.irq_en;

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count_q == $past(reload_q)) && flag_q);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !start) |=> $stable(count_q));

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == $past(reload_q)) && ctrl_q.run);

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(count_q) && !$rose(flag_q));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && flag_clr && !wrap) |=> !flag_q);

    generate
        if (!FIRST) begin : g_link_chk
            p_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_q.link && !link_in && !start) |=> $stable(count_q));
        end
    endgenerate

endmodule

// File: rtl/pit_addr_decode.sv
// Bus address decoder for the timer register map.
// Assumes word-aligned accesses; any nonzero low address bits decode as unmapped.
module pit_addr_decode
    import pit_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic [MAP_AW-1:0] addr,
    output logic              hit_gctrl,
    output logic              hit_life_hi,
    output logic              hit_life_lo,
    output logic              hit_ch,
    output logic [IDX_W-1:0]  ch_idx,
    output ch_reg_e           ch_reg
);

    logic aligned;

    // Classify the address into one register group
    always_comb begin
        aligned     = (addr[1:0] == 2'b00);
        hit_gctrl   = aligned && (addr == ADDR_GCTRL);
        hit_life_hi = aligned && (addr == ADDR_LIFE_HI);
        hit_life_lo = aligned && (addr == ADDR_LIFE_LO);
        ch_idx      = addr[7:4];
        ch_reg      = ch_reg_e'(addr[3:2]);
        hit_ch      = aligned && (addr[11:8] == CH_REGION) && (32'(ch_idx) < NCH);
    end

endmodule

// File: rtl/pit_read_mux.sv
// Read data selection for the timer register map.
// Assumes the decoder's hit signals are mutually exclusive.
module pit_read_mux
    import pit_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    parameter int unsigned CNT_W = 32
) (
    input  logic                      hit_gctrl,
    input  logic                      hit_life_hi,
    input  logic                      hit_life_lo,
    input  logic                      hit_ch,
    input  logic [IDX_W-1:0]          ch_idx,
    input  ch_reg_e                   ch_reg,
    input  logic                      gstop,
    input  logic [CNT_W-1:0]          life_lo_q,
    input  logic [NCH-1:0][CNT_W-1:0] reload_q,
    input  logic [NCH-1:0][CNT_W-1:0] count_q,
    input  logic [NCH-1:0][2:0]       ctrl_q,
    input  logic [NCH-1:0]            flag_q,
    output logic [DATA_W-1:0]         rd_val
);

    // Pick the word addressed by the current request
    always_comb begin
        rd_val = '0;
        if (hit_gctrl) begin
            rd_val[GSTOP_BIT] = gstop;
        end else if (hit_life_hi) begin
            rd_val = DATA_W'(count_q[1]);
        end else if (hit_life_lo) begin
            rd_val = DATA_W'(life_lo_q);
        end else if (hit_ch) begin
            for (int n = 0; n < NCH; n++) begin
                if (32'(ch_idx) == n) begin
                    unique case (ch_reg)
                        CH_RELOAD: rd_val = DATA_W'(reload_q[n]);
                        CH_COUNT:  rd_val = DATA_W'(count_q[n]);
                        CH_CTRL:   rd_val = DATA_W'(ctrl_q[n]);
                        CH_FLAG:   rd_val = DATA_W'(flag_q[n]);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pit_chain_timer.sv
// Top of the chained periodic interrupt timer: bus decode, global stop,
// channel array with wrap chaining, 64-bit capture and registered read data.
// Assumes 2 <= NCH <= 16, CNT_W <= 32, and one bus request per cycle at most.
module pit_chain_timer
    import pit_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [MAP_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);

    logic                      hit_gctrl, hit_life_hi, hit_life_lo, hit_ch;
    logic [IDX_W-1:0]          ch_idx;
    ch_reg_e                   ch_reg;
    logic                      wr_req, rd_req;
    logic                      gstop;
    logic [CNT_W-1:0]          life_lo_q;
    logic [DATA_W-1:0]         rd_val;
    logic [NCH-1:0][CNT_W-1:0] reload_q;
    logic [NCH-1:0][CNT_W-1:0] count_q;
    logic [NCH-1:0][2:0]       ctrl_bits;
    logic [NCH-1:0]            flag_q;
    logic [NCH-1:0]            wrap;
    logic [NCH-1:0]            link;

    // Qualify the bus request by direction
    always_comb begin
        wr_req = bus_sel && bus_wr;
        rd_req = bus_sel && !bus_wr;
    end

    pit_addr_decode #(.NCH(NCH)) u_decode (
        .addr        (bus_addr),
        .hit_gctrl   (hit_gctrl),
        .hit_life_hi (hit_life_hi),
        .hit_life_lo (hit_life_lo),
        .hit_ch      (hit_ch),
        .ch_idx      (ch_idx),
        .ch_reg      (ch_reg)
    );

    // Global stop bit
    always_ff @(posedge clk) begin
        if (!rst_n)                      gstop <= 1'b0;
        else if (wr_req && hit_gctrl)    gstop <= bus_wdata[GSTOP_BIT];
    end

    // Capture channel 0's count when the upper word is read
    always_ff @(posedge clk) begin
        if (!rst_n)                      life_lo_q <= '0;
        else if (rd_req && hit_life_hi)  life_lo_q <= count_q[0];
    end

    // Each channel hears the wrap of the channel below it
    always_comb link = {wrap[NCH-2:0], 1'b0};

    genvar n;
    generate
        for (n = 0; n < NCH; n++) begin : g_ch
            logic     sel_n;
            ch_ctrl_t ctrl_n;

            // Per-channel write selection
            always_comb sel_n = wr_req && hit_ch && (32'(ch_idx) == n);

            pit_channel #(.CNT_W(CNT_W), .FIRST(n == 0)) u_ch (
                .clk          (clk),
                .rst_n        (rst_n),
                .run          (!gstop),
                .link_in      (link[n]),
                .reload_we    (sel_n && ch_reg == CH_RELOAD),
                .reload_wdata (bus_wdata[CNT_W-1:0]),
                .ctrl_we      (sel_n && ch_reg == CH_CTRL),
                .ctrl_wdata   (ch_ctrl_t'(bus_wdata[2:0])),
                .flag_clr     (sel_n && ch_reg == CH_FLAG && bus_wdata[0]),
                .reload_q     (reload_q[n]),
                .count_q      (count_q[n]),
                .ctrl_q       (ctrl_n),
                .flag_q       (flag_q[n]),
                .wrap         (wrap[n]),
                .irq          (irq[n])
            );

            always_comb ctrl_bits[n] = ctrl_n;
        end
    endgenerate

    pit_read_mux #(.NCH(NCH), .CNT_W(CNT_W)) u_rmux (
        .hit_gctrl   (hit_gctrl),
        .hit_life_hi (hit_life_hi),
        .hit_life_lo (hit_life_lo),
        .hit_ch      (hit_ch),
        .ch_idx      (ch_idx),
        .ch_reg      (ch_reg),
        .gstop       (gstop),
        .life_lo_q   (life_lo_q),
        .reload_q    (reload_q),
        .count_q     (count_q),
        .ctrl_q      (ctrl_bits),
        .flag_q      (flag_q),
        .rd_val      (rd_val)
    );

    // Registered read data, zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end

    p_idle_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> bus_rdata == '0);

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hit_life_hi) |=> life_lo_q == $past(count_q[0]));

    p_hi_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hit_life_hi) |=> bus_rdata == DATA_W'($past(count_q[1])));

    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> flag_q[0]);

endmodule

// File: tb/pit_chain_timer_bench.sv
`timescale 1ns/1ps
module pit_chain_timer_bench;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state, built from the requirements
    logic [31:0] m_load [NCH];
    logic [31:0] m_cur  [NCH];
    logic [2:0]  m_ctrl [NCH];
    logic        m_flag [NCH];
    logic        m_stop;
    logic [31:0] m_lat;
    logic [31:0] m_rd;

    always #2.5 clk = ~clk;

    pit_chain_timer #(.NCH(NCH), .CNT_W(32)) u_pit_chain_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        logic [31:0] v;
        v = '0;
        if (a[1:0] != 2'b00) v = '0;
        else if (a == 12'h000) v[1] = m_stop;
        else if (a == 12'h0E0) v = m_cur[1];
        else if (a == 12'h0E4) v = m_lat;
        else if (a[11:8] == 4'h1 && int'(a[7:4]) < NCH) begin
            case (a[3:2])
                2'd0: v = m_load[a[7:4]];
                2'd1: v = m_cur[a[7:4]];
                2'd2: v = {29'b0, m_ctrl[a[7:4]]};
                default: v = {31'b0, m_flag[a[7:4]]};
            endcase
        end
        return v;
    endfunction

    function automatic logic [NCH-1:0] m_irq();
        logic [NCH-1:0] v;
        for (int n = 0; n < NCH; n++) v[n] = m_flag[n] && m_ctrl[n][1];
        return v;
    endfunction

    function automatic bit is_ch_reg(input logic [11:0] a, input int n, input int r);
        return a[1:0] == 2'b00 && a[11:8] == 4'h1 && int'(a[7:4]) == n && int'(a[3:2]) == r;
    endfunction

    task automatic model_reset();
        for (int n = 0; n < NCH; n++) begin
            m_load[n] = '0; m_cur[n] = '0; m_ctrl[n] = '0; m_flag[n] = 1'b0;
        end
        m_stop = 1'b0; m_lat = '0; m_rd = '0;
    endtask

    // One clock of the reference, using the request present at the edge
    task automatic model_step();
        logic ex [NCH];
        logic tk [NCH];
        logic [31:0] old_cur [NCH];
        logic rd_req, wr_req;
        rd_req = sel && !wr;
        wr_req = sel && wr;
        for (int n = 0; n < NCH; n++) begin
            old_cur[n] = m_cur[n];
            tk[n] = !m_stop && m_ctrl[n][0] && (n == 0 || !m_ctrl[n][2] || ex[n-1]);
            ex[n] = tk[n] && (m_cur[n] == 0);
        end
        m_rd = rd_req ? m_read(addr) : 32'h0;
        if (rd_req && addr == 12'h0E0) m_lat = old_cur[0];
        for (int n = 0; n < NCH; n++) begin
            if (wr_req && is_ch_reg(addr, n, 2) && wdata[0] && !m_ctrl[n][0]) m_cur[n] = m_load[n];
            else if (ex[n]) m_cur[n] = m_load[n];
            else if (tk[n]) m_cur[n] = m_cur[n] - 1;
            if (ex[n]) m_flag[n] = 1'b1;
            else if (wr_req && is_ch_reg(addr, n, 3) && wdata[0]) m_flag[n] = 1'b0;
        end
        if (wr_req) begin
            if (addr == 12'h000) m_stop = wdata[1];
            for (int n = 0; n < NCH; n++) begin
                if (is_ch_reg(addr, n, 0)) m_load[n] = wdata;
                if (is_ch_reg(addr, n, 2)) m_ctrl[n] = wdata[2:0];
            end
        end
    endtask

    // One bus cycle: drive at the falling edge, compare after the next rising edge
    task automatic bus_op(input logic s, input logic w, input logic [11:0] a,
                          input logic [31:0] d, input string tag);
        sel = s; wr = w; addr = a; wdata = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R8 irq", 32'(irq), 32'(m_irq()));
        if (s && !w) check(tag, rdata, m_rd);
        if (!s || w) check("R2 idle rdata", rdata, 32'h0);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        bus_op(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic wrt(input logic [11:0] a, input logic [31:0] d, input string tag);
        bus_op(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) bus_op(1'b0, 1'b0, 12'h0, 32'h0, "R2");
    endtask

    initial begin
        #(1_000_000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] a;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 rdata", rdata, 32'h0);
        rd(12'h000, "R1 gctrl");
        rd(12'h100, "R1 reload");
        rd(12'h104, "R1 count");
        rd(12'h108, "R1 ctrl");
        rd(12'h10C, "R1 flag");
        rd(12'h0E4, "R1 life lo");

        // R3: countdown, wrap, reload, flag
        wrt(12'h100, 32'd3, "R3");
        wrt(12'h108, 32'd3, "R3");
        for (int i = 0; i < 10; i++) rd(12'h104, "R3 count");
        rd(12'h10C, "R3 flag");

        // R7: write 0 keeps the flag, write 1 clears it
        wrt(12'h108, 32'd2, "R7");
        wrt(12'h10C, 32'd0, "R7");
        rd(12'h10C, "R7 flag kept");
        wrt(12'h10C, 32'd1, "R7");
        rd(12'h10C, "R7 flag cleared");

        // R4: disabled channel holds, re-enable loads from reload
        wrt(12'h100, 32'd5, "R4");
        rd(12'h104, "R4 hold");
        idle(3);
        rd(12'h104, "R4 hold");
        wrt(12'h108, 32'd3, "R4");
        rd(12'h104, "R4 restart");
        rd(12'h104, "R4 restart");

        // R7: clear request in the wrap cycle keeps the flag set
        wrt(12'h100, 32'd0, "R7");
        wrt(12'h108, 32'd0, "R7");
        wrt(12'h108, 32'd3, "R7");
        wrt(12'h10C, 32'd1, "R7 clear on wrap");
        rd(12'h10C, "R7 set wins");

        // R10: count register is read-only, life words ignore writes
        wrt(12'h104, 32'hDEAD_BEEF, "R10");
        rd(12'h104, "R10 count");
        wrt(12'h0E4, 32'h1234_5678, "R10");
        rd(12'h0E4, "R10 life lo");

        // R5: linked channel steps on the lower channel's wrap; channel 0 ignores link
        wrt(12'h100, 32'd1, "R5");
        wrt(12'h110, 32'd2, "R5");
        wrt(12'h118, 32'd5, "R5");
        wrt(12'h108, 32'd7, "R5");
        for (int i = 0; i < 12; i++) rd(12'h114, "R5 linked count");
        for (int i = 0; i < 4; i++) rd(12'h104, "R5 ch0 ignores link");
        wrt(12'h11C, 32'd1, "R5");
        rd(12'h11C, "R5 linked flag");

        // R6: global stop freezes counting and flag setting
        wrt(12'h10C, 32'd1, "R6");
        wrt(12'h000, 32'd2, "R6");
        rd(12'h000, "R6 gctrl");
        idle(4);
        rd(12'h104, "R6 frozen");
        rd(12'h114, "R6 frozen");
        rd(12'h10C, "R6 no flag");
        wrt(12'h120, 32'd9, "R6");
        rd(12'h120, "R6 access");
        wrt(12'h000, 32'd0, "R6");

        // R9: coherent 64-bit read
        wrt(12'h100, 32'd6, "R9");
        for (int i = 0; i < 5; i++) begin
            rd(12'h0E0, "R9 life hi");
            idle(i);
            rd(12'h0E4, "R9 life lo");
        end

        // R2: unmapped addresses
        rd(12'h140, "R2 slot beyond NCH");
        rd(12'h200, "R2 unmapped");
        rd(12'h102, "R2 misaligned");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int kind;
            int ch;
            int rg;
            kind = $urandom_range(0, 9);
            ch = $urandom_range(0, NCH - 1);
            rg = $urandom_range(0, 3);
            case (kind)
                0: a = 12'h000;
                1: a = ($urandom_range(0, 1) == 0) ? 12'h0E0 : 12'h0E4;
                2: a = 12'h300 + 12'($urandom_range(0, 255) * 4);
                default: a = 12'h100 + 12'(ch * 16) + 12'(rg * 4);
            endcase
            if (a == 12'h000) d = ($urandom_range(0, 7) == 0) ? 32'd2 : 32'd0;
            else if (a[3:2] == 2'd0) d = $urandom_range(0, 12);
            else if (a[3:2] == 2'd2) d = $urandom_range(0, 7);
            else if (a[3:2] == 2'd3) d = $urandom_range(0, 1);
            else d = $urandom;
            if ($urandom_range(0, 9) < 4) wrt(a, d, "R2 random");
            else if ($urandom_range(0, 4) == 0) idle(1);
            else rd(a, "R2 random read");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule